// File: doc/BRIEF.md
# Stack Word Push/Pop Sequencer

This block moves 16-bit words between a processor and a byte-wide memory through a 16-bit stack pointer. An operation is started with a one-cycle request carrying the operation code, the current stack pointer and, for push and exchange, the register-pair word. The sequencer then issues one byte access per memory cycle over a request/ready handshake. It finishes with a single-cycle done pulse and presents the updated stack pointer and, for pop and exchange, the word taken from memory.

There are three operations. Push pre-decrements the pointer before each byte and stores the high byte first, so the low byte lands at the lower address. Pop reads the low byte at the pointer and post-increments, then reads the high byte and post-increments again. Exchange swaps the register pair with the little-endian word at the top of the stack and leaves the pointer unchanged. It captures both memory bytes before it writes either one. All pointer arithmetic wraps modulo 65536.

Top module: `stack_word_seq`

## Requirements
- R1: After reset, busy, done and mem_req are low and sp_out is 0x0000.
- R2: Push (op_code 2'b01) issues exactly two writes: the high byte of word_in to sp_in-1, then the low byte to sp_in-2. sp_out is sp_in-2 at done.
- R3: Pop (op_code 2'b10) issues exactly two reads and no write: address sp_in supplies the low result byte and sp_in+1 supplies the high byte. sp_out is sp_in+2 at done.
- R4: All addresses and sp_out wrap modulo 2^16. A push at 0x0000 writes 0xFFFF then 0xFFFE and ends with 0xFFFE. A pop at 0xFFFF reads 0xFFFF then 0x0000 and ends with 0x0001.
- R5: Exchange (op_code 2'b11) makes four accesses in this order: read sp_in, read sp_in+1, write the low byte of word_in to sp_in, write the high byte to sp_in+1. result is the old memory word (high byte from sp_in+1). sp_out equals sp_in.
- R6: During an exchange, both reads complete before the first write is issued.
- R7: An access completes only in a cycle where mem_req and mem_ready are both high. While mem_ready is low, mem_req, mem_addr, mem_we and mem_wdata hold their values.
- R8: done is high for exactly one cycle, starting in the cycle after the final access completes. busy is low again in the cycle after done.
- R9: A request is ignored when busy is high, or when op_code is 2'b00. In either case no access is added and no result changes.
- R10: A pop issued at the pointer returned by a push returns the pushed word and the original pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation request, sampled while idle |
| op_code | input | 2 | 01 push, 10 pop, 11 exchange, 00 none |
| sp_in | input | 16 | Stack pointer at the start of the operation |
| word_in | input | 16 | Register-pair word for push or exchange |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ready | input | 1 | Memory accepts or answers the access this cycle |
| mem_rdata | input | 8 | Read byte, valid while mem_ready is high |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| result | output | 16 | Word read by pop or exchange |
| sp_out | output | 16 | Stack pointer after the operation |

## Verification
The bench targets the pointer wrap in both directions. A design that extends the sum or borrows into a wider word would write to or return an address outside the 16-bit space. It checks exact byte order and addresses for each operation, because swapped lanes or decrement-after-write would misplace the high byte. For exchange, it checks that the reads come before the writes; a design that interleaved them would return the word it had just written. It also checks that stalled handshakes, requests made while busy, and empty requests neither repeat, add nor lose an access.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PUSH = 2'b01,
        OP_POP  = 2'b10,
        OP_SWAP = 2'b11
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stk_wrap_step.sv
module stk_wrap_step #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic signed [1:0] delta_i,
    output logic [ADDR_W-1:0] sum_o
);
    logic [ADDR_W-1:0] delta_ext;
    assign delta_ext = {{(ADDR_W-2){delta_i[1]}}, delta_i};
    // the sum is truncated to ADDR_W bits, which gives the modulo wrap
    assign sum_o = base_i + delta_ext;
endmodule

// File: rtl/stk_lane_pick.sv
module stk_lane_pick #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*BYTE_W-1:0] word_i,
    input  logic [SEL_W-1:0]        sel_i,
    output logic [BYTE_W-1:0]       byte_o
);
    logic [BYTE_W-1:0] lane_arr [LANES];
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_arr[g] = word_i[g*BYTE_W +: BYTE_W];
    end
    assign byte_o = lane_arr[sel_i];
endmodule

// File: rtl/stk_lane_merge.sv
module stk_lane_merge #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [LANES*BYTE_W-1:0] word_i,
    input  logic [SEL_W-1:0]        sel_i,
    input  logic [BYTE_W-1:0]       byte_i,
    output logic [LANES*BYTE_W-1:0] word_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*BYTE_W +: BYTE_W] =
            (sel_i == SEL_W'(g)) ? byte_i : word_i[g*BYTE_W +: BYTE_W];
    end
endmodule

// File: rtl/stack_word_seq.sv
module stack_word_seq
    import stk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_valid,
    input  logic [1:0]          op_code,
    input  logic [ADDR_W-1:0]   sp_in,
    input  logic [2*BYTE_W-1:0] word_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [BYTE_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic                done,
    output logic                busy,
    output logic [2*BYTE_W-1:0] result,
    output logic [ADDR_W-1:0]   sp_out
);
    localparam int LANES  = 2;
    localparam int WORD_W = LANES * BYTE_W;
    localparam int SEL_W  = $clog2(LANES);

    typedef struct packed {
        stk_state_e        st;
        stk_op_e           op;
        logic [1:0]        step;
        logic [ADDR_W-1:0] ptr;
        logic [WORD_W-1:0] wr_word;
        logic [WORD_W-1:0] rd_word;
    } regs_t;

    regs_t r_d, r_q;

    logic              is_push, is_pop, is_swap, last_step, wr_now;
    logic [SEL_W-1:0]  lane_sel;
    logic signed [1:0] addr_delta;
    logic [ADDR_W-1:0] acc_addr, ptr_plus1;
    logic [BYTE_W-1:0] wr_byte;
    logic [WORD_W-1:0] rd_merged;

    assign is_push = (r_q.op == OP_PUSH);
    assign is_pop  = (r_q.op == OP_POP);
    assign is_swap = (r_q.op == OP_SWAP);
    // push stores the high lane first; pop and exchange begin with the low lane
    assign lane_sel   = is_push ? ~r_q.step[0] : r_q.step[0];
    assign addr_delta = is_push ? -2'sd1 : ((is_swap && r_q.step[0]) ? 2'sd1 : 2'sd0);
    assign last_step  = is_swap ? (r_q.step == 2'd3) : (r_q.step == 2'd1);
    // exchange writes only in steps 2 and 3, after both reads
    assign wr_now     = is_push | (is_swap & r_q.step[1]);

    stk_wrap_step #(.ADDR_W(ADDR_W)) u_addr (
        .base_i(r_q.ptr), .delta_i(addr_delta), .sum_o(acc_addr));
    stk_wrap_step #(.ADDR_W(ADDR_W)) u_incr (
        .base_i(r_q.ptr), .delta_i(2'sd1), .sum_o(ptr_plus1));
    stk_lane_pick #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pick (
        .word_i(r_q.wr_word), .sel_i(lane_sel), .byte_o(wr_byte));
    stk_lane_merge #(.BYTE_W(BYTE_W), .LANES(LANES)) u_merge (
        .word_i(r_q.rd_word), .sel_i(lane_sel), .byte_i(mem_rdata), .word_o(rd_merged));

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (op_valid && (op_code != OP_NONE)) begin
                    r_d.st      = ST_RUN;
                    r_d.op      = stk_op_e'(op_code);
                    r_d.step    = 2'd0;
                    r_d.ptr     = sp_in;
                    r_d.wr_word = word_in;
                end
            end
            ST_RUN: begin
                if (mem_ready) begin
                    if (!wr_now) r_d.rd_word = rd_merged;
                    if (is_push)     r_d.ptr = acc_addr;
                    else if (is_pop) r_d.ptr = ptr_plus1;
                    r_d.step = r_q.step + 2'd1;
                    if (last_step) r_d.st = ST_DONE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req   = (r_q.st == ST_RUN);
    assign mem_we    = wr_now;
    assign mem_addr  = acc_addr;
    assign mem_wdata = wr_byte;
    assign done      = (r_q.st == ST_DONE);
    assign busy      = (r_q.st != ST_IDLE);
    assign result    = r_q.rd_word;
    assign sp_out    = r_q.ptr;

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);
    p_done_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_ready));
    p_pop_read_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && is_pop |-> !mem_we);
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);
endmodule

// File: tb/sim_stack_word_seq.sv
module sim_stack_word_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'b00;
    logic [15:0] sp_in = '0, word_in = '0;
    logic        mem_req, mem_we, mem_ready, done, busy;
    logic [15:0] mem_addr, result, sp_out;
    logic [7:0]  mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    stack_word_seq u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .sp_in(sp_in), .word_in(word_in), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rdata(mem_rdata), .done(done), .busy(busy), .result(result), .sp_out(sp_out));

    logic [7:0]  mem [256];
    logic        stall = 1'b0, tog = 1'b0;
    logic        pl_en = 1'b0, log_clr = 1'b0;
    logic [7:0]  pl_addr = '0, pl_data = '0;
    logic [15:0] log_addr [8];
    logic        log_we [8];
    logic [7:0]  log_dat [8];
    int          n_log = 0, cyc = 0, last_cyc = 0;
    int          n_chk = 0, n_fail = 0;

    assign mem_ready = !stall || tog;
    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        tog <= ~tog;
        cyc <= cyc + 1;
        if (pl_en) mem[pl_addr] <= pl_data;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        if (log_clr) n_log <= 0;
        else if (mem_req && mem_ready) begin
            if (n_log < 8) begin
                log_addr[n_log] <= mem_addr;
                log_we[n_log]   <= mem_we;
                log_dat[n_log]  <= mem_we ? mem_wdata : mem_rdata;
            end
            n_log    <= n_log + 1;
            last_cyc <= cyc;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk); pl_en = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [15:0] sp, input logic [15:0] w,
                          input bit inject, output logic [15:0] res, output logic [15:0] spo);
        @(negedge clk); log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
        op_valid = 1'b1; op_code = op; sp_in = sp; word_in = w;
        @(negedge clk); op_valid = 1'b0; op_code = 2'b00;
        if (inject) begin
            op_valid = 1'b1; op_code = 2'b11; sp_in = 16'h0055; word_in = 16'hFFFF;
            @(negedge clk); op_valid = 1'b0; op_code = 2'b00;
        end
        for (int i = 0; i < 64 && !done; i++) @(negedge clk);
        check(done, "R8 done seen", 32'(done), 1);
        check(cyc == last_cyc + 1, "R8 done one cycle after last access", cyc, last_cyc + 1);
        res = result; spo = sp_out;
        @(negedge clk);
        check(!done && !busy, "R8 done single cycle", {30'd0, done, busy}, 0);
    endtask

    task automatic t_reset();
        check(!busy && !done && !mem_req, "R1 reset outputs", {29'd0, busy, done, mem_req}, 0);
        check(sp_out == 16'h0000, "R1 reset sp_out", 32'(sp_out), 0);
    endtask

    task automatic t_push(input logic [15:0] sp, input logic [15:0] w, input bit inj, input string tag);
        logic [15:0] r, s;
        run_op(2'b01, sp, w, inj, r, s);
        check(n_log == 2, {tag, " push access count"}, n_log, 2);
        check(log_addr[0] == sp - 16'd1 && log_we[0] && log_dat[0] == w[15:8],
              {tag, " push high byte first"}, {log_addr[0], log_dat[0]}, {sp - 16'd1, w[15:8]});
        check(log_addr[1] == sp - 16'd2 && log_we[1] && log_dat[1] == w[7:0],
              {tag, " push low byte second"}, {log_addr[1], log_dat[1]}, {sp - 16'd2, w[7:0]});
        check(s == sp - 16'd2, {tag, " push sp_out"}, 32'(s), 32'(sp - 16'd2));
    endtask

    task automatic t_pop(input logic [15:0] sp, input logic [15:0] expw, input string tag);
        logic [15:0] r, s;
        run_op(2'b10, sp, 16'h0000, 1'b0, r, s);
        check(n_log == 2 && !log_we[0] && !log_we[1], {tag, " pop two reads"}, n_log, 2);
        check(log_addr[0] == sp && log_addr[1] == sp + 16'd1, {tag, " pop addresses"},
              {log_addr[0], log_addr[1]}, {sp, sp + 16'd1});
        check(r == expw, {tag, " pop result"}, 32'(r), 32'(expw));
        check(s == sp + 16'd2, {tag, " pop sp_out"}, 32'(s), 32'(sp + 16'd2));
    endtask

    task automatic t_swap();
        logic [15:0] r, s;
        poke(8'h30, 8'hCD); poke(8'h31, 8'hAB);
        stall = 1'b1;
        run_op(2'b11, 16'h1230, 16'h1234, 1'b0, r, s);
        stall = 1'b0;
        check(n_log == 4, "R5 exchange access count", n_log, 4);
        check(!log_we[0] && !log_we[1] && log_we[2] && log_we[3], "R6 reads before writes",
              {log_we[0], log_we[1], log_we[2], log_we[3]}, 4'b0011);
        check(log_addr[0] == 16'h1230 && log_addr[1] == 16'h1231 && log_addr[2] == 16'h1230
              && log_addr[3] == 16'h1231, "R5 exchange addresses",
              {log_addr[0], log_addr[3]}, {16'h1230, 16'h1231});
        check(log_dat[2] == 8'h34 && log_dat[3] == 8'h12, "R5 exchange write data",
              {log_dat[2], log_dat[3]}, 16'h3412);
        check(r == 16'hABCD, "R5 exchange result", 32'(r), 32'hABCD);
        check(s == 16'h1230, "R5 exchange sp unchanged", 32'(s), 32'h1230);
        check(mem[8'h30] == 8'h34 && mem[8'h31] == 8'h12, "R5 exchange memory",
              {mem[8'h30], mem[8'h31]}, 16'h3412);
    endtask

    task automatic t_wrap();
        poke(8'hFF, 8'h77); poke(8'h00, 8'h88);
        t_pop(16'hFFFF, 16'h8877, "R4 wrap");
        t_push(16'h0000, 16'h5AA5, 1'b0, "R4 wrap");
    endtask

    task automatic t_round();
        stall = 1'b1;
        t_push(16'h8000, 16'hBEEF, 1'b0, "R10 R7 stalled");
        t_pop(16'h7FFE, 16'hBEEF, "R10 R7 stalled");
        stall = 1'b0;
    endtask

    task automatic t_ignore();
        logic [15:0] r, s;
        run_op(2'b01, 16'h4010, 16'hC3E1, 1'b1, r, s);
        check(n_log == 2 && s == 16'h400E, "R9 request while busy ignored", {n_log[15:0], s}, {16'd2, 16'h400E});
        repeat (4) @(negedge clk);
        check(n_log == 2 && !busy, "R9 no deferred operation", n_log, 2);
        op_valid = 1'b1; op_code = 2'b00; sp_in = 16'h0020;
        @(negedge clk); op_valid = 1'b0;
        repeat (3) @(negedge clk);
        check(n_log == 2 && !busy && sp_out == 16'h400E, "R9 empty op_code ignored",
              {n_log[15:0], sp_out}, {16'd2, 16'h400E});
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_push(16'h2000, 16'h1357, 1'b0, "R2");
        t_pop(16'h1FFE, 16'h1357, "R3");
        t_wrap();
        t_swap();
        t_round();
        t_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule